// File: doc/BRIEF.md
# Parity-Conditional Call and Return Sequencer

This block is the control unit of an 8-bit processor with a 16-bit address that handles two instructions: a subroutine call taken only when the parity flag is set, and an unconditional return. It holds the program counter and the stack pointer and runs one machine cycle after another on a simple memory bus. Each clock is one state. A machine cycle keeps its address on the bus for all of its states and raises a read or write strobe in its second and third states.

A call first fetches its opcode and then reads a two-byte target, low byte first. If the parity flag is set at the end of the second read, the unit pushes the return address onto the stack, high byte first at the higher address, and jumps to the target. If the flag is clear, execution moves on to the byte after the three-byte instruction. A return pops the low byte and then the high byte and resumes there. Every other opcode is a one-byte operation that does nothing. The stack pointer is set through a load port.

Top module: `cond_call_unit`

## Requirements
- R1: While `rst` is high, `pc_q` reads 0x0000, `sp_q` reads `SP_INIT` (default 0x0000) and neither strobe is active. In the first state after release, `op_sync` is high and `bus_addr` is 0x0000.
- R2: Every instruction starts with an opcode fetch. In the fetch, `op_sync` is high in state 1, `bus_addr` equals `pc_q`, and `bus_rd` is high in states 2 and 3. The fetch lasts 6 states for opcode 0xEC and 4 states for any other opcode.
- R3: After an 0xEC fetch, two 3-state read cycles follow. The first reads the target low byte at opcode address + 1. The second reads the target high byte at opcode address + 2.
- R4: If `parity_flag` is 1 in the last state of the high-byte read, two 3-state write cycles follow. The first writes the high byte of the return address (opcode address + 3) to `sp_q`-1. The second writes the low byte to the original `sp_q`-2. The stack pointer ends 2 lower, the next fetch is at the target, and the instruction takes 18 states.
- R5: If `parity_flag` is 0 at that point, no write cycle occurs. The next fetch is at opcode address + 3, the stack pointer is unchanged, and the instruction takes 12 states.
- R6: Opcode 0xC9 is followed by two 3-state reads, at `sp_q` and then at `sp_q`+1. The program counter becomes {second byte, first byte`}`, the stack pointer rises by 2, and the instruction takes 10 states.
- R7: Any opcode other than 0xEC and 0xC9 takes 4 states and issues no further bus cycle. The next fetch is at opcode address + 1 and the stack pointer is unchanged.
- R8: When `sp_load` is high at a clock edge outside reset, `sp_q` takes `sp_value` at that edge. A load takes priority over a stack pointer update in the same state.
- R9: `bus_rd` and `bus_wr` are never high together. Each strobe pulse lasts exactly 2 states, and the address of the second write of a call is one below the address of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sp_load | input | 1 | Load the stack pointer from `sp_value` |
| sp_value | input | 16 | New stack pointer value |
| parity_flag | input | 1 | Parity flag, 1 when the last result had even parity |
| bus_rdata | input | 8 | Read data returned by memory |
| bus_addr | output | 16 | Address of the current machine cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| op_sync | output | 1 | High in the first state of every opcode fetch |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |

## Verification
A wrong machine-cycle state shows at the next strobe as an unexpected read or write, or as a wrong address. It also shows at the next `op_sync` as an instruction length outside 4, 10, 12 and 18. Both signs appear within one instruction of the fault. A corrupted target or return register does no harm until the pushed bytes are read back, so calls are paired with returns. A bad value then surfaces as a wrong `pc_q` at the first fetch after the return. A stack pointer that drifts shows at once in the address of the next stack cycle and in `sp_q` at the next instruction boundary.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [2:0] {
    MC_FETCH,
    MC_OPLO,
    MC_OPHI,
    MC_PUSHH,
    MC_PUSHL,
    MC_POPL,
    MC_POPH
  } mcyc_e;

  // strobe window inside every machine cycle (1-based state numbers)
  localparam int STB_FIRST = 2;
  localparam int STB_LAST  = 3;

endpackage

// File: rtl/ccu_ctrl.sv
module ccu_ctrl
  import ccu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OP_CALL = 'hEC,
  parameter logic [DATA_W-1:0] OP_RET  = 'hC9,
  parameter int FETCH_LONG  = 6,
  parameter int FETCH_SHORT = 4,
  parameter int MEM_LEN     = 3,
  localparam int TW = $clog2(FETCH_LONG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rdata,
  input  logic              parity,
  output mcyc_e             mc,
  output logic              strobe_on,
  output logic              sample,
  output logic              cyc_end,
  output logic              sync
);

  logic [TW-1:0]     tcnt;
  logic [TW-1:0]     cyc_len;
  logic [DATA_W-1:0] ir;
  mcyc_e             mc_nxt;

  assign strobe_on = (tcnt >= TW'(STB_FIRST)) && (tcnt <= TW'(STB_LAST));
  assign sample    = (tcnt == TW'(STB_LAST));
  assign cyc_end   = (tcnt == cyc_len);
  assign sync      = (mc == MC_FETCH) && (tcnt == TW'(1));

  // the opcode is latched in state 3; the fetch length is only consulted from state 4 on
  always_comb begin
    if (mc == MC_FETCH)
      cyc_len = (ir == OP_CALL) ? TW'(FETCH_LONG) : TW'(FETCH_SHORT);
    else
      cyc_len = TW'(MEM_LEN);
  end

  always_comb begin
    case (mc)
      MC_FETCH: begin
        if (ir == OP_CALL)     mc_nxt = MC_OPLO;
        else if (ir == OP_RET) mc_nxt = MC_POPL;
        else                   mc_nxt = MC_FETCH;
      end
      MC_OPLO:  mc_nxt = MC_OPHI;
      MC_OPHI:  mc_nxt = parity ? MC_PUSHH : MC_FETCH;
      MC_PUSHH: mc_nxt = MC_PUSHL;
      MC_PUSHL: mc_nxt = MC_FETCH;
      MC_POPL:  mc_nxt = MC_POPH;
      MC_POPH:  mc_nxt = MC_FETCH;
      default:  mc_nxt = MC_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc   <= MC_FETCH;
      tcnt <= TW'(1);
      ir   <= '0;
    end else begin
      if ((mc == MC_FETCH) && sample)
        ir <= rdata;
      if (cyc_end) begin
        mc   <= mc_nxt;
        tcnt <= TW'(1);
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

endmodule

// File: rtl/ccu_regs.sv
module ccu_regs
  import ccu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] SP_INIT = '0,
  localparam int AW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mcyc_e             mc,
  input  logic              sample,
  input  logic              cyc_end,
  input  logic [DATA_W-1:0] rdata,
  input  logic              sp_load,
  input  logic [AW-1:0]     sp_value,
  output logic [AW-1:0]     pc,
  output logic [AW-1:0]     sp
);

  logic [AW-1:0] tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      sp  <= SP_INIT;
      tgt <= '0;
    end else begin
      case (mc)
        MC_FETCH: begin
          if (cyc_end) pc <= pc + AW'(1);
        end
        MC_OPLO: begin
          if (sample)  tgt[DATA_W-1:0] <= rdata;
          if (cyc_end) pc <= pc + AW'(1);
        end
        MC_OPHI: begin
          if (sample)  tgt[AW-1:DATA_W] <= rdata;
          if (cyc_end) pc <= pc + AW'(1);
        end
        MC_PUSHH: begin
          if (cyc_end) sp <= sp - AW'(1);
        end
        MC_PUSHL: begin
          if (cyc_end) begin
            sp <= sp - AW'(1);
            pc <= tgt;
          end
        end
        MC_POPL: begin
          if (sample)  tgt[DATA_W-1:0] <= rdata;
          if (cyc_end) sp <= sp + AW'(1);
        end
        MC_POPH: begin
          if (sample)  pc <= {rdata, tgt[DATA_W-1:0]};
          if (cyc_end) sp <= sp + AW'(1);
        end
        default: ;
      endcase
      if (sp_load)
        sp <= sp_value;
    end
  end

endmodule

// File: rtl/ccu_busdrv.sv
module ccu_busdrv
  import ccu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W
) (
  input  mcyc_e             mc,
  input  logic              strobe_on,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     sp,
  output logic [AW-1:0]     addr,
  output logic              rd,
  output logic              wr,
  output logic [DATA_W-1:0] wdata
);

  logic is_push;
  logic is_pop;

  assign is_push = (mc == MC_PUSHH) || (mc == MC_PUSHL);
  assign is_pop  = (mc == MC_POPL)  || (mc == MC_POPH);

  always_comb begin
    if (is_push)     addr = sp - AW'(1);
    else if (is_pop) addr = sp;
    else             addr = pc;
  end

  assign rd    = strobe_on && !is_push;
  assign wr    = strobe_on && is_push;
  assign wdata = (mc == MC_PUSHH) ? pc[AW-1:DATA_W] :
                 (mc == MC_PUSHL) ? pc[DATA_W-1:0]  : '0;

endmodule

// File: rtl/cond_call_unit.sv
module cond_call_unit
  import ccu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OP_CALL = 'hEC,
  parameter logic [DATA_W-1:0] OP_RET  = 'hC9,
  parameter int FETCH_LONG  = 6,
  parameter int FETCH_SHORT = 4,
  parameter int MEM_LEN     = 3,
  parameter logic [2*DATA_W-1:0] SP_INIT = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sp_load,
  input  logic [2*DATA_W-1:0] sp_value,
  input  logic                parity_flag,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic [2*DATA_W-1:0] bus_addr,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic                op_sync,
  output logic [2*DATA_W-1:0] pc_q,
  output logic [2*DATA_W-1:0] sp_q
);

  mcyc_e mc;
  logic  strobe_on;
  logic  sample;
  logic  cyc_end;

  ccu_ctrl #(
    .DATA_W(DATA_W), .OP_CALL(OP_CALL), .OP_RET(OP_RET),
    .FETCH_LONG(FETCH_LONG), .FETCH_SHORT(FETCH_SHORT), .MEM_LEN(MEM_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rdata(bus_rdata), .parity(parity_flag),
    .mc(mc), .strobe_on(strobe_on), .sample(sample), .cyc_end(cyc_end),
    .sync(op_sync)
  );

  ccu_regs #(.DATA_W(DATA_W), .SP_INIT(SP_INIT)) u_regs (
    .clk(clk), .rst(rst), .mc(mc), .sample(sample), .cyc_end(cyc_end),
    .rdata(bus_rdata), .sp_load(sp_load), .sp_value(sp_value),
    .pc(pc_q), .sp(sp_q)
  );

  ccu_busdrv #(.DATA_W(DATA_W)) u_bus (
    .mc(mc), .strobe_on(strobe_on), .pc(pc_q), .sp(sp_q),
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata)
  );

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int DATA_W      = 8,
  parameter int FETCH_LONG  = 6,
  parameter int FETCH_SHORT = 4,
  parameter int MEM_LEN     = 3,
  localparam int AW = 2 * DATA_W
) (
  input logic          clk,
  input logic          rst,
  input logic          sp_load,
  input logic [AW-1:0] sp_value,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          op_sync,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] sp_q
);

  localparam int LEN_OTHER = FETCH_SHORT;
  localparam int LEN_RET   = FETCH_SHORT + 2 * MEM_LEN;
  localparam int LEN_SKIP  = FETCH_LONG + 2 * MEM_LEN;
  localparam int LEN_TAKEN = FETCH_LONG + 4 * MEM_LEN;
  localparam int CW        = $clog2(LEN_TAKEN + 2) + 1;

  logic [CW-1:0] len_cnt;
  logic          seen;
  logic          ld_seen;
  logic [AW-1:0] sp_at_sync;
  logic          wr_seen;
  logic [AW-1:0] last_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_cnt    <= '0;
      seen       <= 1'b0;
      ld_seen    <= 1'b0;
      sp_at_sync <= '0;
      wr_seen    <= 1'b0;
      last_wr    <= '0;
    end else begin
      if (op_sync) begin
        len_cnt    <= CW'(1);
        seen       <= 1'b1;
        ld_seen    <= sp_load;
        sp_at_sync <= sp_q;
        wr_seen    <= 1'b0;
      end else begin
        len_cnt <= len_cnt + CW'(1);
        ld_seen <= ld_seen | sp_load;
        if (bus_wr) begin
          wr_seen <= 1'b1;
          last_wr <= bus_addr;
        end
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));  // R9

  AST_WR_DESCEND: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_wr) && wr_seen) |-> (bus_addr == last_wr - AW'(1)));  // R4

  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
    op_sync |-> (bus_addr == pc_q));  // R2

  AST_SP_LOAD: assert property (@(posedge clk) disable iff (rst)
    sp_load |=> (sp_q == $past(sp_value)));  // R8

  AST_INSTR_LEN: assert property (@(posedge clk) disable iff (rst)
    (op_sync && seen) |-> (len_cnt == CW'(LEN_OTHER) || len_cnt == CW'(LEN_RET) ||
                           len_cnt == CW'(LEN_SKIP)  || len_cnt == CW'(LEN_TAKEN)));  // R7

  AST_SP_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (op_sync && seen && !ld_seen) |->
      ((len_cnt == CW'(LEN_TAKEN) && sp_q == sp_at_sync - AW'(2)) ||
       (len_cnt == CW'(LEN_RET)   && sp_q == sp_at_sync + AW'(2)) ||
       ((len_cnt == CW'(LEN_OTHER) || len_cnt == CW'(LEN_SKIP)) && sp_q == sp_at_sync)));  // R6

endmodule

bind cond_call_unit ccu_checker #(
  .DATA_W(DATA_W), .FETCH_LONG(FETCH_LONG), .FETCH_SHORT(FETCH_SHORT), .MEM_LEN(MEM_LEN)
) u_chk (
  .clk(clk), .rst(rst), .sp_load(sp_load), .sp_value(sp_value),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .op_sync(op_sync),
  .pc_q(pc_q), .sp_q(sp_q)
);

// File: tb/tb_cond_call_unit.sv
`timescale 1ns/1ps
module tb_cond_call_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sp_load = 1'b0;
  logic [15:0] sp_value = '0;
  logic        parity_flag = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic        op_sync;
  logic [15:0] pc_q;
  logic [15:0] sp_q;

  always #2 clk = ~clk;

  cond_call_unit dut (
    .clk(clk), .rst(rst), .sp_load(sp_load), .sp_value(sp_value),
    .parity_flag(parity_flag), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .op_sync(op_sync), .pc_q(pc_q), .sp_q(sp_q)
  );

  logic [7:0] mem [0:4095];
  logic [7:0] exp_mem [0:4095];
  assign bus_rdata = bus_rd ? mem[bus_addr[11:0]] : 8'h00;

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } bus_item_t;

  typedef struct {
    int          len;
    logic [15:0] pc;
    logic [15:0] sp;
    bit          par;
    bit          ld;
    logic [15:0] ldv;
    string       req;
  } ins_item_t;

  bus_item_t bq[$];
  ins_item_t iq[$];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] m_pc;
  logic [15:0] m_sp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_bus(input bit wr, input logic [15:0] a, input logic [7:0] d, input string req);
    bus_item_t b;
    b.wr = wr; b.addr = a; b.data = d; b.req = req;
    bq.push_back(b);
  endtask

  task automatic push_ins(input int len, input bit par, input bit ld, input logic [15:0] ldv,
                          input string req);
    ins_item_t it;
    it.len = len; it.pc = m_pc; it.sp = m_sp; it.par = par; it.ld = ld; it.ldv = ldv;
    it.req = req;
    iq.push_back(it);
  endtask

  // one-byte operation, optional stack pointer load at its first state
  task automatic op_other(input logic [7:0] opc, input bit ld, input logic [15:0] ldv);
    mem[m_pc[11:0]] = opc;
    push_bus(0, m_pc, 8'h00, "R2");
    m_pc = m_pc + 16'd1;
    if (ld) m_sp = ldv;
    push_ins(4, 1'b0, ld, ldv, ld ? "R8" : "R7");
  endtask

  task automatic op_call(input logic [15:0] target, input bit par);
    logic [15:0] ret;
    mem[m_pc[11:0]]          = 8'hEC;
    mem[m_pc[11:0] + 12'd1]  = target[7:0];
    mem[m_pc[11:0] + 12'd2]  = target[15:8];
    push_bus(0, m_pc, 8'h00, "R2");
    push_bus(0, m_pc + 16'd1, 8'h00, "R3");
    push_bus(0, m_pc + 16'd2, 8'h00, "R3");
    ret = m_pc + 16'd3;
    if (par) begin
      push_bus(1, m_sp - 16'd1, ret[15:8], "R4");
      push_bus(1, m_sp - 16'd2, ret[7:0], "R4");
      exp_mem[m_sp[11:0] - 12'd1] = ret[15:8];
      exp_mem[m_sp[11:0] - 12'd2] = ret[7:0];
      m_sp = m_sp - 16'd2;
      m_pc = target;
      push_ins(18, 1'b1, 1'b0, 16'h0, "R4");
    end else begin
      m_pc = ret;
      push_ins(12, 1'b0, 1'b0, 16'h0, "R5");
    end
  endtask

  task automatic op_ret();
    mem[m_pc[11:0]] = 8'hC9;
    push_bus(0, m_pc, 8'h00, "R2");
    push_bus(0, m_sp, 8'h00, "R6");
    push_bus(0, m_sp + 16'd1, 8'h00, "R6");
    m_pc = {exp_mem[m_sp[11:0] + 12'd1], exp_mem[m_sp[11:0]]};
    m_sp = m_sp + 16'd2;
    push_ins(10, 1'b0, 1'b0, 16'h0, "R6");
  endtask

  // scoreboard monitor
  bit          have_prev = 0;
  bit          prev_stb  = 0;
  int          stb_len   = 0;
  int          st_cnt    = 0;
  bit          ld_pend   = 0;
  logic [15:0] ld_val;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (bus_rd && bus_wr) chk("R9", 32'd1, 32'd0);
      if (bus_wr) mem[bus_addr[11:0]] = bus_wdata;

      if (bus_rd || bus_wr) begin
        if (!prev_stb) begin
          stb_len = 1;
          if (bq.size() == 0) begin
            chk("R9", {15'b0, bus_wr, bus_addr}, 32'hFFFF_FFFF);
          end else begin
            bus_item_t b;
            b = bq.pop_front();
            chk(b.req, {15'b0, bus_wr, bus_addr}, {15'b0, b.wr, b.addr});
            if (b.wr) chk(b.req, {24'b0, bus_wdata}, {24'b0, b.data});
          end
        end else begin
          stb_len++;
        end
      end else if (prev_stb) begin
        chk("R9", stb_len, 2);
      end
      prev_stb = bus_rd || bus_wr;

      if (ld_pend) begin
        chk("R8", {16'b0, sp_q}, {16'b0, ld_val});
        sp_load = 1'b0;
        ld_pend = 0;
      end

      if (op_sync) begin
        if (have_prev) begin
          ins_item_t it;
          it = iq.pop_front();
          chk(it.req, st_cnt, it.len);
          chk(it.req, {16'b0, pc_q}, {16'b0, it.pc});
          chk(it.req, {16'b0, sp_q}, {16'b0, it.sp});
        end else begin
          have_prev = 1;
          chk("R1", {16'b0, bus_addr}, 32'h0);
        end
        if (iq.size() == 0) begin
          chk("R7", bq.size(), 0);
          done = 1;
        end else begin
          parity_flag = iq[0].par;
          if (iq[0].ld) begin
            sp_load  = 1'b1;
            sp_value = iq[0].ldv;
            ld_val   = iq[0].ldv;
            ld_pend  = 1;
          end
        end
        st_cnt = 1;
      end else begin
        st_cnt++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i]     = 8'h00;
      exp_mem[i] = 8'h00;
    end
    mem[12'h900] = 8'hAB; exp_mem[12'h900] = 8'hAB;
    mem[12'h901] = 8'h03; exp_mem[12'h901] = 8'h03;
    m_pc = 16'h0000;
    m_sp = 16'h0000;
    op_other(8'h00, 1'b1, 16'h0800);   // R8 load at the first fetch
    op_call(16'h0210, 1'b1);           // R4 taken
    op_ret();                          // R6 back to 0x0004
    op_call(16'h0134, 1'b0);           // R5 not taken
    op_other(8'h3E, 1'b0, 16'h0);      // R7
    op_call(16'h0FFE, 1'b1);           // R4 taken, return 0x000B
    op_ret();                          // R6
    op_other(8'h00, 1'b1, 16'h0900);   // R8 move stack onto preloaded bytes
    op_ret();                          // R6 to 0x03AB
    op_call(16'h0020, 1'b1);           // R4 from an odd address
    op_other(8'h76, 1'b0, 16'h0);      // R7

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {16'b0, pc_q}, 32'h0);
    chk("R1", {16'b0, sp_q}, 32'h0);
    chk("R1", {30'b0, bus_rd, bus_wr}, 32'h0);
    rst = 1'b0;

    wait (done);
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule